// File: doc/BRIEF.md
# Integer Execute Unit with Immediate Operands

This block is the arithmetic and logic stage of a simple 32-bit integer pipeline. It is purely combinational. A decoder gives it two register operands (A from the first source register, B from the second), the 16-bit immediate field of the instruction, the 5-bit shift-amount field and a small control word. From these it returns one 32-bit result and an equality flag. A branch unit uses the equality flag to decide taken versus not-taken on equal/not-equal branches.

The control word has three parts. A 3-bit operation code picks the function. A source select picks whether the second operand is register B or the immediate. An extend select picks whether the immediate is sign-extended or zero-extended. This lets one adder serve several needs. Register adds, immediate adds and load/store effective addresses all use the adder with a sign-extended offset. The logical immediates use the bitwise path with a zero-extended constant.

Shifts take their count from the instruction's shift-amount field, not from a register, and always shift operand B. Arithmetic wraps modulo 2^32 and raises no trap.

The block has no clock and no state. The house-style state machine therefore collapses to a single named mode: "evaluate", with no transitions. Every input change is reflected at the outputs in the same cycle.

Top module: `xu_exec_unit`

## Requirements
- R1: With op code 0 (add), result equals A plus the second operand, modulo 2^32. With the source select at 1 and the extend select at 1, this is the load/store effective address: base A plus the sign-extended 16-bit offset, which reaches from -32768 to +32767.
- R2: With op code 1 (subtract), result equals A minus the second operand, modulo 2^32.
- R3: With op code 2, result is the bitwise AND of A and the second operand. With op code 3, result is the bitwise OR of A and the second operand.
- R4: With op code 4 (set-less-than), result is 1 when A is less than the second operand under two's-complement signed comparison, and 0 otherwise. Bits 31:1 are always 0.
- R5: With op code 5, result is B shifted left by the shift-amount field. With op code 6, result is B shifted right by the shift-amount field. Vacated bits are filled with zeros, and a count of 0 passes B unchanged.
- R6: With op code 7 (load upper), result holds the 16-bit immediate in bits 31:16 and zeros in bits 15:0. A and B have no effect on the result.
- R7: With the source select at 0, the second operand is B. With the source select at 1 and the extend select at 1, the second operand is the immediate sign-extended from bit 15. With the source select at 1 and the extend select at 0, the second operand is the immediate zero-extended. For example, OR with zero-extended 252 sets only bits 7:2 of A.
- R8: The equality flag is 1 exactly when A equals B. It does not depend on the op code, the immediate or the selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 32 | First register operand (base for addresses) |
| opnd_b | input | 32 | Second register operand (shift source) |
| imm_field | input | 16 | Immediate field of the instruction |
| shamt_field | input | 5 | Shift amount field of the instruction |
| op_sel | input | 3 | Operation code: 0 add, 1 sub, 2 and, 3 or, 4 slt, 5 sll, 6 srl, 7 lui |
| use_imm | input | 1 | 1 selects the extended immediate as second operand |
| imm_sext | input | 1 | 1 sign-extends the immediate, 0 zero-extends it |
| result | output | 32 | Operation result |
| equal | output | 1 | High when opnd_a equals opnd_b |

## Verification
The equality flag and the result are produced in the same evaluation. A branch compare of A and B therefore always coincides with whatever operation the result path is carrying, such as an effective address or a subtraction on the same operands. The bench provokes this by driving many vectors where A equals B, or differs by one bit, under every op code and both operand sources. It judges the flag and the result independently against a behavioural model in every cycle. Corner vectors cover signed wrap at the adder, negative offsets, shift counts of 0 and 31, and the load-upper path with garbage on A and B.

// File: rtl/xu_pkg.sv
package xu_pkg;

    localparam int XU_DATA_W  = 32;
    localparam int XU_IMM_W   = 16;
    localparam int XU_SHAMT_W = $clog2(XU_DATA_W);

    typedef enum logic [2:0] {
        XU_ADD = 3'd0,
        XU_SUB = 3'd1,
        XU_AND = 3'd2,
        XU_OR  = 3'd3,
        XU_SLT = 3'd4,
        XU_SLL = 3'd5,
        XU_SRL = 3'd6,
        XU_LUI = 3'd7
    } xu_op_e;

endpackage

// File: rtl/xu_imm_ext.sv
module xu_imm_ext #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [IMM_W-1:0]  imm_i,
    input  logic              sext_i,
    output logic [DATA_W-1:0] ext_o
);
    localparam int PAD_W = DATA_W - IMM_W;

    logic fill_bit;

    always_comb begin
        fill_bit = sext_i & imm_i[IMM_W-1];
        ext_o    = {{PAD_W{fill_bit}}, imm_i};
    end

    // R7
    always_comb begin
        zext_upper_chk: assert (sext_i || (ext_o[DATA_W-1:IMM_W] == '0))
            else $error("zero extension left upper bits set");
    end
endmodule

// File: rtl/xu_arith.sv
module xu_arith #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] opnd_i,
    input  logic [DATA_W-1:0] cmp_b_i,
    input  logic              sub_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              less_o,
    output logic              equal_o
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] plus_val;
    logic [DATA_W-1:0] minus_val;
    logic [DATA_W-1:0] cmp_diff;
    logic              sub_ovf;

    always_comb begin
        plus_val  = a_i + opnd_i;
        minus_val = a_i - opnd_i;
        sum_o     = sub_i ? minus_val : plus_val;
        sub_ovf   = (a_i[MSB] != opnd_i[MSB]) && (minus_val[MSB] != a_i[MSB]);
        less_o    = minus_val[MSB] ^ sub_ovf;
        cmp_diff  = a_i - cmp_b_i;
        equal_o   = (cmp_diff == '0);
    end

    // R8
    always_comb begin
        eq_flag_chk: assert (equal_o == (a_i == cmp_b_i))
            else $error("equality flag disagrees with operand compare");
    end

    // R4
    always_comb begin
        signed_less_chk: assert (less_o == ($signed(a_i) < $signed(opnd_i)))
            else $error("signed compare wrong");
    end
endmodule

// File: rtl/xu_shift.sv
module xu_shift #(
    parameter int DATA_W  = 32,
    parameter int SHAMT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0]  val_i,
    input  logic [SHAMT_W-1:0] amt_i,
    input  logic               left_i,
    output logic [DATA_W-1:0]  val_o
);
    logic [DATA_W-1:0]              rev_in;
    logic [DATA_W-1:0]              rev_out;
    logic [SHAMT_W:0][DATA_W-1:0]   stage;

    for (genvar i = 0; i < DATA_W; i++) begin : g_rev
        assign rev_in[i]  = val_i[DATA_W-1-i];
        assign rev_out[i] = stage[SHAMT_W][DATA_W-1-i];
    end

    assign stage[0] = left_i ? rev_in : val_i;

    for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
        assign stage[k+1] = amt_i[k] ? (stage[k] >> (1 << k)) : stage[k];
    end

    assign val_o = left_i ? rev_out : stage[SHAMT_W];

    // R5
    always_comb begin
        shift_fill_chk: assert ((amt_i == '0) || (left_i ? (val_o[0] == 1'b0)
                                                         : (val_o[DATA_W-1] == 1'b0)))
            else $error("vacated bit not zero");
    end
endmodule

// File: rtl/xu_exec_unit.sv
module xu_exec_unit
    import xu_pkg::*;
#(
    parameter int DATA_W  = XU_DATA_W,
    parameter int IMM_W   = XU_IMM_W,
    parameter int SHAMT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0]  opnd_a,
    input  logic [DATA_W-1:0]  opnd_b,
    input  logic [IMM_W-1:0]   imm_field,
    input  logic [SHAMT_W-1:0] shamt_field,
    input  logic [2:0]         op_sel,
    input  logic               use_imm,
    input  logic               imm_sext,
    output logic [DATA_W-1:0]  result,
    output logic               equal
);
    localparam int LOW_W = DATA_W - IMM_W;

    xu_op_e            op;
    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] opnd_2;
    logic [DATA_W-1:0] arith_val;
    logic              less_val;
    logic [DATA_W-1:0] shift_val;

    assign op     = xu_op_e'(op_sel);
    assign opnd_2 = use_imm ? imm_ext : opnd_b;

    xu_imm_ext #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_ext (
        .imm_i  (imm_field),
        .sext_i (imm_sext),
        .ext_o  (imm_ext)
    );

    xu_arith #(.DATA_W(DATA_W)) u_arith (
        .a_i     (opnd_a),
        .opnd_i  (opnd_2),
        .cmp_b_i (opnd_b),
        .sub_i   (op == XU_SUB),
        .sum_o   (arith_val),
        .less_o  (less_val),
        .equal_o (equal)
    );

    xu_shift #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_shift (
        .val_i  (opnd_b),
        .amt_i  (shamt_field),
        .left_i (op == XU_SLL),
        .val_o  (shift_val)
    );

    always_comb begin
        unique case (op)
            XU_ADD,
            XU_SUB:  result = arith_val;
            XU_AND:  result = opnd_a & opnd_2;
            XU_OR:   result = opnd_a | opnd_2;
            XU_SLT:  result = {{(DATA_W-1){1'b0}}, less_val};
            XU_SLL,
            XU_SRL:  result = shift_val;
            XU_LUI:  result = {imm_field, {LOW_W{1'b0}}};
            default: result = '0;
        endcase
    end

    // R2
    always_comb begin
        sub_inverse_chk: assert ((op != XU_SUB) || use_imm || ((result + opnd_b) == opnd_a))
            else $error("subtract result does not invert");
    end

    // R4
    always_comb begin
        slt_range_chk: assert ((op != XU_SLT) || (result[DATA_W-1:1] == '0))
            else $error("set-less-than upper bits set");
    end

    // R6
    always_comb begin
        lui_low_clear_chk: assert ((op != XU_LUI) || ((result[LOW_W-1:0] == '0)
                                   && (result[DATA_W-1:LOW_W] == imm_field)))
            else $error("load-upper placement wrong");
    end

    // R3
    always_comb begin
        or_keeps_a_chk: assert ((op != XU_OR) || ((result & opnd_a) == opnd_a))
            else $error("OR cleared a bit of A");
    end
endmodule

// File: tb/xu_exec_unit_bench.sv
module xu_exec_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [15:0] imm_field = '0;
    logic [4:0]  shamt_field = '0;
    logic [2:0]  op_sel = '0;
    logic        use_imm = 1'b0;
    logic        imm_sext = 1'b0;
    logic [31:0] result;
    logic        equal;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    xu_exec_unit u_xu_exec_unit (
        .opnd_a      (opnd_a),
        .opnd_b      (opnd_b),
        .imm_field   (imm_field),
        .shamt_field (shamt_field),
        .op_sel      (op_sel),
        .use_imm     (use_imm),
        .imm_sext    (imm_sext),
        .result      (result),
        .equal       (equal)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected < 150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic string tag_of(input logic [2:0] op, input logic ui);
        case (op)
            3'd0: return ui ? "R1/R7" : "R1";
            3'd1: return ui ? "R2/R7" : "R2";
            3'd2, 3'd3: return ui ? "R3/R7" : "R3";
            3'd4: return ui ? "R4/R7" : "R4";
            3'd5, 3'd6: return "R5";
            default: return "R6";
        endcase
    endfunction

    function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
                                          input logic [15:0] im, input logic [4:0] sh,
                                          input logic [2:0] op, input logic ui,
                                          input logic se);
        longint      sx;
        logic [31:0] second;
        sx = se ? longint'($signed(im)) : longint'(im);
        second = ui ? sx[31:0] : b;
        case (op)
            3'd0: return 32'(longint'(a) + longint'(second));
            3'd1: return 32'(longint'(a) - longint'(second));
            3'd2: return a & second;
            3'd3: return a | second;
            3'd4: return (int'(a) < int'(second)) ? 32'd1 : 32'd0;
            3'd5: return b << sh;
            3'd6: return b >> sh;
            default: return {im, 16'h0000};
        endcase
    endfunction

    task automatic apply(input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] im, input logic [4:0] sh,
                         input logic [2:0] op, input logic ui, input logic se);
        logic [31:0] exp_res;
        @(posedge clk);
        #1;
        opnd_a = a; opnd_b = b; imm_field = im; shamt_field = sh;
        op_sel = op; use_imm = ui; imm_sext = se;
        @(negedge clk);
        exp_res = model(a, b, im, sh, op, ui, se);
        checks++;
        if (result !== exp_res) begin
            failures++;
            $display("FAIL %s op=%0d: result actual=%h expected=%h", tag_of(op, ui), op,
                     result, exp_res);
        end
        checks++;
        if (equal !== (a == b)) begin
            failures++;
            $display("FAIL R8 op=%0d: equal actual=%b expected=%b", op, equal, (a == b));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // idle state with zero inputs: add of zeros, operands equal (R1, R8)
        checks++;
        if (result !== 32'h0 || equal !== 1'b1) begin
            failures++;
            $display("FAIL R1/R8 idle: actual result=%h equal=%b expected 0/1", result, equal);
        end
        rst_n = 1'b1;

        // R1 wrap and effective address with negative and positive offsets
        apply(32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0, 3'd0, 1'b0, 1'b0);
        apply(32'h7FFF_FFFF, 32'h1, 16'h0, 5'd0, 3'd0, 1'b0, 1'b0);
        apply(32'h0000_0010, 32'h0, 16'h0008, 5'd0, 3'd0, 1'b1, 1'b1);
        apply(32'h0000_1000, 32'h0, 16'h8000, 5'd0, 3'd0, 1'b1, 1'b1);
        apply(32'h0000_1000, 32'h0, 16'h7FFF, 5'd0, 3'd0, 1'b1, 1'b1);
        // R2 wrap
        apply(32'h0, 32'h1, 16'h0, 5'd0, 3'd1, 1'b0, 1'b0);
        apply(32'h8000_0000, 32'h1, 16'h0, 5'd0, 3'd1, 1'b0, 1'b0);
        // R3 and R7: OR with zero-extended 252, AND with zero-extended negative-looking imm
        apply(32'hD050_40F0, 32'h0, 16'd252, 5'd0, 3'd3, 1'b1, 1'b0);
        apply(32'hFFFF_FFFF, 32'h0, 16'hFFFF, 5'd0, 3'd2, 1'b1, 1'b0);
        apply(32'hDF5A_48F5, 32'hF0F0_F0F0, 16'h0, 5'd0, 3'd2, 1'b0, 1'b0);
        // R4 signed compare corners
        apply(32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0, 3'd4, 1'b0, 1'b0);
        apply(32'h1, 32'hFFFF_FFFF, 16'h0, 5'd0, 3'd4, 1'b0, 1'b0);
        apply(32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 5'd0, 3'd4, 1'b0, 1'b0);
        apply(32'h5, 32'h5, 16'h0, 5'd0, 3'd4, 1'b0, 1'b0);
        apply(32'h0000_0003, 32'h0, 16'hFFFF, 5'd0, 3'd4, 1'b1, 1'b1);
        // R5 shift counts 0, 8, 31
        apply(32'h0, 32'hDF5A_48F5, 16'h0, 5'd8, 3'd5, 1'b0, 1'b0);
        apply(32'h0, 32'h5A48_F500, 16'h0, 5'd4, 3'd6, 1'b0, 1'b0);
        apply(32'h0, 32'hDEAD_BEEF, 16'h0, 5'd0, 3'd5, 1'b0, 1'b0);
        apply(32'h0, 32'hFFFF_FFFF, 16'h0, 5'd31, 3'd6, 1'b0, 1'b0);
        apply(32'h0, 32'hFFFF_FFFF, 16'h0, 5'd31, 3'd5, 1'b0, 1'b0);
        // R6 load-upper ignores A and B
        apply(32'h1234_5678, 32'h9ABC_DEF0, 16'hAAAA, 5'd3, 3'd7, 1'b0, 1'b1);
        apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0001, 5'd0, 3'd7, 1'b1, 1'b0);
        // R8 equality alongside every op, equal and one-bit-apart operands
        for (int op = 0; op < 8; op++) begin
            apply(32'hCAFE_0042, 32'hCAFE_0042, 16'h8001, 5'd7, 3'(op), 1'b1, 1'b1);
            apply(32'hCAFE_0042, 32'hCAFE_0043, 16'h0001, 5'd7, 3'(op), 1'b0, 1'b0);
        end
        // random sweep over all ops and operand sources
        for (int n = 0; n < 2000; n++) begin
            logic [31:0] ra;
            logic [31:0] rb;
            ra = $urandom;
            rb = ($urandom_range(0, 3) == 0) ? ra : 32'($urandom);
            apply(ra, rb, 16'($urandom), 5'($urandom), 3'($urandom), 1'($urandom),
                  1'($urandom));
        end

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule